// File: doc/BRIEF.md
# AXI Write Response Ordering Checker

A passive monitor for the write address, write data and write response channels of one AXI link. It watches the VALID/READY pairs (and the last-beat marker on the data channel) and flags any write response that shows up before the handshakes it depends on are complete. It drives nothing on the bus. The only outputs are a sticky error flag and a two-bit error code.

A run-time mode input selects the dependency rule. In the older rule (AXI3) a response depends only on the final data beat. A responder may therefore take all beats, answer, and accept the address afterwards. The checker records such an early response as an address debt, and the next address handshake pays that debt off. In the stricter rule (AXI4) both the address handshake and the final data handshake must be complete before BVALID may rise. The monitor assumes in-order traffic with a single ID. It does not look at IDs, data, addresses, burst lengths or the read channels.

Top module: `wr_resp_order_chk`

## Requirements
- R1: An address handshake counts only on a rising clock edge where aw_valid_i and aw_ready_i are both 1. aw_valid_i without aw_ready_i adds no address credit.
- R2: A data-channel handshake gives a last-data credit only when w_last_i is 1 together with w_valid_i and w_ready_i. Handshakes on non-last beats give no credit.
- R3: In either mode, b_valid_i high in a cycle with no last-data credit raises err_o on the next edge with err_code_o = 2'b01.
- R4: With mode_axi4_i = 1, b_valid_i high while a last-data credit exists but no address credit exists raises err_o with err_code_o = 2'b10. A missing data credit takes priority and gives 2'b01.
- R5: With mode_axi4_i = 0, a response that follows the final data beat is legal without a prior address handshake. The address that arrives later settles the debt and adds no new address credit.
- R6: A response handshake (b_valid_i and b_ready_i both 1) consumes one last-data credit and one address credit. A counter already at zero stays at zero.
- R7: err_o is sticky. While err_o is 1 and clr_i is 0, err_o stays 1 and err_code_o keeps the code of the first violation.
- R8: A clr_i pulse clears err_o and err_code_o to 0 on the next edge and leaves all credit counters unchanged. A violation in the same cycle as clr_i wins and loads its own code.
- R9: rst_ni low asynchronously clears err_o, err_code_o and every credit and debt counter.
- R10: Credit counters saturate at 2**CNT_W-1. Further handshakes beyond that are not counted.
- R11: Credits are judged as they stood before the current edge. A b_valid_i in the same cycle as the final data handshake is a violation (2'b01).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_axi4_i | input | 1 | 1 = AXI4 rule, 0 = AXI3 rule |
| clr_i | input | 1 | Synchronous clear of the error flag |
| aw_valid_i | input | 1 | Observed address VALID |
| aw_ready_i | input | 1 | Observed address READY |
| w_valid_i | input | 1 | Observed data VALID |
| w_ready_i | input | 1 | Observed data READY |
| w_last_i | input | 1 | Observed final-beat marker |
| b_valid_i | input | 1 | Observed response VALID |
| b_ready_i | input | 1 | Observed response READY |
| err_o | output | 1 | Sticky ordering violation flag |
| err_code_o | output | 2 | 01 missing data, 10 missing address |

## Verification
Counter saturation is the hardest state to reach from the ports. It only shows once the credit count at its ceiling is drained. The stimulus runs twenty paired address and final-data handshakes in AXI4 mode, then issues responses until the data credit runs out. The sixteenth response must fail. The address debt of the AXI3 rule is also indirect. It is exposed by paying the debt with a late address, switching to AXI4 mode, and showing that no spare address credit remains.

// File: rtl/wrchk_pkg.sv
package wrchk_pkg;
  typedef enum logic [1:0] {
    ERR_NONE    = 2'b00,
    ERR_NO_DATA = 2'b01,
    ERR_NO_ADDR = 2'b10
  } err_code_e;

  localparam int unsigned CH_ADDR = 0;
  localparam int unsigned CH_DATA = 1;
  localparam int unsigned CH_DEBT = 2;
  localparam int unsigned NUM_CH  = 3;
endpackage

// File: rtl/wrchk_ctr.sv
module wrchk_ctr #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i && !dec_i && cnt_q != MAX) cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  p_sat_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX && inc_i && !dec_i) |=> cnt_q == MAX);
  p_no_underflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && dec_i && !inc_i) |=> cnt_q == '0);
endmodule

// File: rtl/wrchk_err_flag.sv
module wrchk_err_flag
  import wrchk_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      viol_i,
  input  err_code_e code_i,
  input  logic      clr_i,
  output logic      err_o,
  output err_code_e code_o
);
  logic      err_q;
  err_code_e code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      code_q <= ERR_NONE;
    end else if (viol_i) begin
      err_q <= 1'b1;
      // first violation wins unless cleared this cycle
      if (!err_q || clr_i) code_q <= code_i;
    end else if (clr_i) begin
      err_q  <= 1'b0;
      code_q <= ERR_NONE;
    end
  end

  assign err_o  = err_q;
  assign code_o = code_q;

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !clr_i) |=> (err_q && $stable(code_q)));
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !viol_i) |=> (!err_q && code_q == ERR_NONE));
  p_code_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> code_q != ERR_NONE);
endmodule

// File: rtl/wr_resp_order_chk.sv
module wr_resp_order_chk
  import wrchk_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_axi4_i,
  input  logic       clr_i,
  input  logic       aw_valid_i,
  input  logic       aw_ready_i,
  input  logic       w_valid_i,
  input  logic       w_ready_i,
  input  logic       w_last_i,
  input  logic       b_valid_i,
  input  logic       b_ready_i,
  output logic       err_o,
  output logic [1:0] err_code_o
);
  logic aw_hs, wl_hs, b_hs;
  logic [NUM_CH-1:0] inc, dec, zero;
  logic [CNT_W-1:0]  cnt [NUM_CH];
  logic      viol;
  err_code_e viol_code, code_q;

  assign aw_hs = aw_valid_i && aw_ready_i;
  assign wl_hs = w_valid_i && w_ready_i && w_last_i;
  assign b_hs  = b_valid_i && b_ready_i;

  // a late address first repays a response already given (AXI3)
  assign inc[CH_ADDR] = aw_hs && zero[CH_DEBT];
  assign dec[CH_ADDR] = b_hs && (!zero[CH_ADDR] || inc[CH_ADDR]);
  assign inc[CH_DATA] = wl_hs;
  assign dec[CH_DATA] = b_hs && (!zero[CH_DATA] || inc[CH_DATA]);
  assign inc[CH_DEBT] = b_hs && zero[CH_ADDR] && !inc[CH_ADDR] && !mode_axi4_i;
  assign dec[CH_DEBT] = aw_hs && !zero[CH_DEBT];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ctr
    wrchk_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (inc[g]),
      .dec_i  (dec[g]),
      .cnt_o  (cnt[g]),
      .zero_o (zero[g])
    );
  end

  always_comb begin
    viol      = 1'b0;
    viol_code = ERR_NONE;
    if (b_valid_i && zero[CH_DATA]) begin
      viol      = 1'b1;
      viol_code = ERR_NO_DATA;
    end else if (b_valid_i && mode_axi4_i && zero[CH_ADDR]) begin
      viol      = 1'b1;
      viol_code = ERR_NO_ADDR;
    end
  end

  wrchk_err_flag u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .viol_i (viol),
    .code_i (viol_code),
    .clr_i  (clr_i),
    .err_o  (err_o),
    .code_o (code_q)
  );

  assign err_code_o = code_q;

  p_data_err_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_valid_i && cnt[CH_DATA] == '0) |=> err_o);
  p_addr_err_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_axi4_i && b_valid_i && cnt[CH_DATA] != '0 && cnt[CH_ADDR] == '0 && (!err_o || clr_i))
    |=> (err_o && err_code_o == 2'b10));
  p_axi3_ok_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_axi4_i && b_valid_i && cnt[CH_DATA] != '0 && !err_o) |=> !err_o);
  p_no_data_credit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(w_valid_i && w_ready_i && w_last_i) && !b_hs) |=> $stable(cnt[CH_DATA]));
  p_no_addr_credit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(aw_valid_i && aw_ready_i) && !b_hs) |=> $stable(cnt[CH_ADDR]));
endmodule

// File: tb/wr_resp_order_chk_tb_top.sv
module wr_resp_order_chk_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0, clr = 1'b0;
  logic awv = 1'b0, awr = 1'b0, wv = 1'b0, wr = 1'b0, wl = 1'b0, bv = 1'b0, br = 1'b0;
  logic err;
  logic [1:0] code;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  typedef struct { logic e; logic [1:0] c; string tag; } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  wr_resp_order_chk dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_axi4_i(mode), .clr_i(clr),
    .aw_valid_i(awv), .aw_ready_i(awr), .w_valid_i(wv), .w_ready_i(wr),
    .w_last_i(wl), .b_valid_i(bv), .b_ready_i(br),
    .err_o(err), .err_code_o(code)
  );

  task automatic check(input logic ae, input logic [1:0] ac,
                       input logic ee, input logic [1:0] ec, input string tag);
    n_chk++;
    if (ae !== ee || ac !== ec) begin
      n_err++;
      $display("FAIL %s: err=%0b code=%b expected err=%0b code=%b", tag, ae, ac, ee, ec);
    end
  endtask

  // driver: apply one cycle of stimulus, queue the result expected after the edge
  task automatic drv(input bit a_v, a_r, d_v, d_r, d_l, r_v, r_r, c,
                     input bit ee, input bit [1:0] ec, input string tag);
    @(negedge clk);
    awv = a_v; awr = a_r; wv = d_v; wr = d_r; wl = d_l; bv = r_v; br = r_r; clr = c;
    sb_q.push_back('{ee, ec, tag});
  endtask

  task automatic idle(input bit ee, input bit [1:0] ec, input string tag);
    drv(0,0,0,0,0,0,0,0, ee, ec, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    awv = 0; awr = 0; wv = 0; wr = 0; wl = 0; bv = 0; br = 0; clr = 0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(err, code, 1'b0, 2'b00, "R9 reset state");
    rst_n = 1'b1;
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t x;
        x = sb_q.pop_front();
        check(err, code, x.e, x.c, x.tag);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: err=%0b code=%b expected completion", err, code);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    idle(0, 2'b00, "R9 idle after reset");

    // R3 AXI3: response with nothing before it
    mode = 1'b0;
    drv(0,0,0,0,0,1,0,0, 1, 2'b01, "R3 no data credit axi3");
    idle(1, 2'b01, "R7 sticky");
    drv(0,0,0,0,0,0,0,1, 0, 2'b00, "R8 clear");

    // R1/R4 AXI4: address valid without ready, last data done
    do_reset();
    mode = 1'b1;
    drv(1,0,0,0,0,0,0,0, 0, 2'b00, "R1 aw valid only");
    drv(1,0,1,1,1,0,0,0, 0, 2'b00, "R2 last beat");
    drv(0,0,0,0,0,1,1,0, 1, 2'b10, "R4 missing address axi4");

    // R2: non-last beat gives no credit
    do_reset();
    drv(1,1,0,0,0,0,0,0, 0, 2'b00, "R1 aw handshake");
    drv(0,0,1,1,0,0,0,0, 0, 2'b00, "R2 non-last beat");
    drv(0,0,0,0,0,1,0,0, 1, 2'b01, "R2 no credit from non-last");

    // R6: normal AXI4 then credit consumed
    do_reset();
    drv(1,1,1,1,1,0,0,0, 0, 2'b00, "R6 aw+last");
    drv(0,0,0,0,0,1,1,0, 0, 2'b00, "R6 legal response axi4");
    drv(0,0,0,0,0,1,0,0, 1, 2'b01, "R6 credit consumed");

    // R5: data-first responder in AXI3, late address repays debt
    do_reset();
    mode = 1'b0;
    drv(0,0,1,1,1,0,0,0, 0, 2'b00, "R5 last beat first");
    drv(0,0,0,0,0,1,1,0, 0, 2'b00, "R5 early response allowed axi3");
    drv(1,1,0,0,0,0,0,0, 0, 2'b00, "R5 late address");
    mode = 1'b1;
    drv(0,0,1,1,1,0,0,0, 0, 2'b00, "R5 next last beat");
    drv(0,0,0,0,0,1,0,0, 1, 2'b10, "R5 late address left no credit");

    // R11: response in the same cycle as the last beat
    do_reset();
    drv(1,1,0,0,0,0,0,0, 0, 2'b00, "R11 aw");
    drv(0,0,1,1,1,1,0,0, 1, 2'b01, "R11 same-cycle response");
    drv(0,0,0,0,0,0,0,1, 0, 2'b00, "R8 clear keeps counters");
    drv(0,0,0,0,0,1,1,0, 0, 2'b00, "R8 credits survived clear");

    // R7 first code held, R8 set wins over clear
    do_reset();
    drv(0,0,0,0,0,1,0,0, 1, 2'b01, "R7 first violation");
    drv(0,0,1,1,1,0,0,0, 1, 2'b01, "R7 hold");
    drv(0,0,0,0,0,1,0,0, 1, 2'b01, "R7 second violation keeps code");
    drv(0,0,0,0,0,1,0,1, 1, 2'b10, "R8 violation wins over clear");
    drv(0,0,0,0,0,0,0,1, 0, 2'b00, "R8 clear");

    // R9: reset drops credits
    do_reset();
    drv(1,1,1,1,1,0,0,0, 0, 2'b00, "R9 credits before reset");
    do_reset();
    drv(0,0,0,0,0,1,0,0, 1, 2'b01, "R9 credits gone after reset");

    // R10: saturation at 15
    do_reset();
    for (int i = 0; i < 20; i++) drv(1,1,1,1,1,0,0,0, 0, 2'b00, "R10 fill");
    for (int i = 0; i < 15; i++) drv(0,0,0,0,0,1,1,0, 0, 2'b00, "R10 drain");
    drv(0,0,0,0,0,1,0,0, 1, 2'b01, "R10 saturated count exhausted");
    idle(1, 2'b01, "R10 flag held");

    @(posedge clk);
    #3;
    while (sb_q.size() > 0) @(posedge clk);
    #3;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule